// File: doc/BRIEF.md
# Two-level IO address translator

This block sits between IO devices that issue DMA bus addresses and the memory system, and turns each bus address into a physical address. The upper bus-address bits select one of 64 first-level entries held in on-chip registers. Such an entry either maps one large region directly or points to a second-level table in memory. In the second case the block reads one 32-bit entry from that table through a simple read port. The 4 KiB page offset is never translated.

Software programs the first-level entries, a control word and an invalidate register through a small write/read register port. The control word holds a global enable and a two-bit window-size code. An eight-entry fully associative translation cache keeps recent page translations. A cache hit answers one cycle after the request is accepted. A miss that needs a table read holds off further requests until the memory answers. Any bus address that falls outside the window, and any invalid entry met on the way, produces a fault response.

Top module: `iomap_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_rd_req` are 0, and the control word (byte offset 0x100) reads back 0, so translation is off.
- R2: While the enable bit (control bit 8) is 0, an accepted request answers on the next cycle with `rsp_paddr` equal to the zero-extended bus address, no fault and no memory read.
- R3: Control bits 1:0 pick the window: 0 covers 256 MiB, 1 covers 2 GiB and 3 covers 128 GiB. A bus address at or above the window size faults. Code 2 faults every address. The control word reads back what was written in bits 8 and 1:0.
- R4: Each first-level entry spans 1/64 of the window: 4 MiB, 32 MiB or 2 GiB. The first-level index is the six bus-address bits just above the span. First-level entry i is written at byte offset 4*i. A second-level read goes to (entry bits 29:0 shifted left by 12) plus 4 times the page number inside the span. Each miss issues exactly one read.
- R5: A first-level entry with bit 31 set maps the whole span directly. Its page number is bits 29:2 with two zero low bits, plus the page number inside the span. Bit 1 is returned as cached and bit 0 as priority, and no memory read is made. With bit 31 clear and bit 30 set, the entry points to a table. With both bits clear, the entry faults.
- R6: In a second-level entry, bit 31 marks it valid, bit 30 is returned as cached and bits 29:0 are the page number. The result is {page number, bus address bits 11:0}. An entry with bit 31 clear faults.
- R7: A request whose page is held in the translation cache answers one cycle after acceptance with the cached result and makes no memory read.
- R8: The cache holds 8 page translations and replaces them round-robin. The ninth distinct fill after a flush evicts the first one, and the next fill evicts the second.
- R9: Writing value V to the invalidate register (byte offset 0x104) drops every cached page whose bus address shifted right by 14 equals V. Other cached pages are kept.
- R10: Any write to a first-level entry or to the control word empties the whole cache.
- R11: While a table read is pending, `req_ready` is 0, and at most one read is outstanding.
- R12: A fault response carries physical address 0 and clear flags. Faults are never cached, so repeating a faulting request repeats its table read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register byte offset (write and read) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 40 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation fault |
| rsp_paddr | output | 42 | Physical address |
| rsp_cached | output | 1 | Cached attribute of the mapping |
| rsp_prio | output | 1 | Priority attribute of the mapping |
| mem_rd_req | output | 1 | One-cycle second-level read request |
| mem_rd_addr | output | 42 | Physical byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Second-level entry read |

## Verification
The assertions check the following on every cycle:
- a fault always comes with a zero address and clear flags;
- a good result keeps the page offset of the accepted address;
- a table read is a single-cycle pulse that only occurs while new requests are held off;
- a cache hit and the disabled bypass both answer on the next cycle;
- at most one cache entry matches a lookup.

Only the bench scenarios can show the following:
- the address arithmetic for each window size;
- the large-page and table formats;
- round-robin eviction order;
- the region matched by an invalidate;
- the flush triggered by a configuration write.

// File: rtl/iox_pkg.sv
`timescale 1ns/1ps
package iox_pkg;
  parameter int unsigned BA_W   = 40;
  parameter int unsigned PPN_W  = 30;
  parameter int unsigned PG_SH  = 12;
  parameter int unsigned L1_N   = 64;
  localparam int unsigned PA_W  = PPN_W + PG_SH;
  localparam int unsigned L1_IW = $clog2(L1_N);
  localparam int unsigned TAG_W = BA_W - PG_SH;
  localparam int unsigned INV_W = BA_W - 14;

  typedef enum logic {ST_IDLE, ST_WALK} walk_st_t;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic             cached;
    logic             prio;
  } xl_res_t;

  // log2 of the bytes covered by one first-level entry
  function automatic int unsigned span_sh(input logic [1:0] win);
    case (win)
      2'd0:    return 22;
      2'd3:    return 31;
      default: return 25;
    endcase
  endfunction

  function automatic logic in_window(input logic [BA_W-1:0] a, input logic [1:0] win);
    if (win == 2'd2) return 1'b0;
    return (a >> (span_sh(win) + L1_IW)) == '0;
  endfunction

  function automatic logic [L1_IW-1:0] l1_idx(input logic [BA_W-1:0] a, input logic [1:0] win);
    logic [BA_W-1:0] t;
    t = a >> span_sh(win);
    return t[L1_IW-1:0];
  endfunction

  // page number inside the span of one first-level entry
  function automatic logic [PPN_W-1:0] span_page(input logic [BA_W-1:0] a, input logic [1:0] win);
    logic [BA_W-1:0] m, t;
    m = (BA_W'(1) << span_sh(win)) - BA_W'(1);
    t = (a & m) >> PG_SH;
    return t[PPN_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] l2_addr(input logic [PPN_W-1:0] base, input logic [PPN_W-1:0] pg);
    return {base, {PG_SH{1'b0}}} + PA_W'({pg, 2'b00});
  endfunction

  function automatic logic [PPN_W-1:0] big_ppn(input logic [PPN_W-1:0] field, input logic [PPN_W-1:0] pg);
    return {field[PPN_W-1:2], 2'b00} + pg;
  endfunction
endpackage

// File: rtl/iox_cfg_regs.sv
`timescale 1ns/1ps
module iox_cfg_regs
  import iox_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [8:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [L1_IW-1:0] l1_sel,
  output logic [31:0]      l1_ent,
  output logic             xl_en,
  output logic [1:0]       win,
  output logic             inv_pulse,
  output logic [INV_W-1:0] inv_val,
  output logic             flush
);
  logic [31:0] l1_q [L1_N];
  logic        en_q;
  logic [1:0]  win_q;
  logic        is_l1, is_ctl, is_inv;

  assign is_l1  = (addr[8] == 1'b0);
  assign is_ctl = (addr == 9'h100);
  assign is_inv = (addr == 9'h104);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(L1_N); i++) l1_q[i] <= '0;
      en_q  <= 1'b0;
      win_q <= 2'd0;
    end else if (wr_en) begin
      if (is_l1) l1_q[addr[L1_IW+1:2]] <= wdata;
      if (is_ctl) begin
        en_q  <= wdata[8];
        win_q <= wdata[1:0];
      end
    end
  end

  assign l1_ent    = l1_q[l1_sel];
  assign xl_en     = en_q;
  assign win       = win_q;
  assign inv_pulse = wr_en & is_inv;
  assign inv_val   = wdata[INV_W-1:0];
  assign flush     = wr_en & (is_l1 | is_ctl);

  always_comb begin
    rdata = '0;
    if (is_l1)       rdata = l1_q[addr[L1_IW+1:2]];
    else if (is_ctl) rdata = {23'd0, en_q, 6'd0, win_q};
  end
endmodule

// File: rtl/iox_tlb.sv
`timescale 1ns/1ps
module iox_tlb
  import iox_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output xl_res_t          lk_res,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  xl_res_t          fill_res,
  input  logic             inv_en,
  input  logic [INV_W-1:0] inv_val,
  input  logic             flush
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  xl_res_t          res_q [DEPTH];
  logic [PW-1:0]    ptr_q;
  logic [DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    lk_res = '0;
    for (int i = 0; i < int'(DEPTH); i++)
      if (hit_vec[i]) lk_res = res_q[i];
  end
  assign lk_hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      for (int i = 0; i < int'(DEPTH); i++)
        if (flush || (inv_en && tag_q[i][TAG_W-1:2] == inv_val)) vld_q[i] <= 1'b0;
      if (fill_en) begin
        vld_q[ptr_q] <= 1'b1;
        ptr_q <= (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[ptr_q] <= fill_tag;
      res_q[ptr_q] <= fill_res;
    end
  end

  AST_TLB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R8
endmodule

// File: rtl/iomap_xlate.sv
`timescale 1ns/1ps
module iomap_xlate
  import iox_pkg::*;
#(
  parameter int unsigned TLB_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_en,
  input  logic [8:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [BA_W-1:0] req_addr,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_cached,
  output logic            rsp_prio,
  output logic            mem_rd_req,
  output logic [PA_W-1:0] mem_rd_addr,
  input  logic            mem_rsp_valid,
  input  logic [31:0]     mem_rsp_data
);
  walk_st_t         st_q;
  logic [BA_W-1:0]  acc_addr_q;
  logic             stale_q;
  logic [31:0]      l1e;
  logic             xl_en, inv_pulse, flush, cfg_evt;
  logic [1:0]       win;
  logic [INV_W-1:0] inv_val;
  logic             req_fire, in_win, l1_big, l1_ptr, tlb_hit;
  logic [PPN_W-1:0] pg;
  xl_res_t          hit_res, fill_res;
  logic             fill_en;
  logic [TAG_W-1:0] fill_tag;

  iox_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .l1_sel(l1_idx(req_addr, win)), .l1_ent(l1e), .xl_en(xl_en),
    .win(win), .inv_pulse(inv_pulse), .inv_val(inv_val), .flush(flush)
  );

  assign cfg_evt   = flush | inv_pulse;
  assign req_ready = (st_q == ST_IDLE);
  assign req_fire  = req_valid & req_ready;
  assign in_win    = in_window(req_addr, win);
  assign l1_big    = l1e[31];
  assign l1_ptr    = l1e[30] & ~l1e[31];
  assign pg        = span_page(req_addr, win);

  always_comb begin
    fill_en  = 1'b0;
    fill_tag = req_addr[BA_W-1:PG_SH];
    fill_res = '{ppn: big_ppn(l1e[PPN_W-1:0], pg), cached: l1e[1], prio: l1e[0]};
    if (st_q == ST_WALK) begin
      fill_tag = acc_addr_q[BA_W-1:PG_SH];
      fill_res = '{ppn: mem_rsp_data[PPN_W-1:0], cached: mem_rsp_data[30], prio: 1'b0};
      fill_en  = mem_rsp_valid && mem_rsp_data[31] && !stale_q && !cfg_evt;
    end else begin
      fill_en  = req_fire && xl_en && in_win && !tlb_hit && l1_big && !cfg_evt;
    end
  end

  iox_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
    .clk(clk), .rst_n(rst_n), .lk_tag(req_addr[BA_W-1:PG_SH]), .lk_hit(tlb_hit),
    .lk_res(hit_res), .fill_en(fill_en), .fill_tag(fill_tag), .fill_res(fill_res),
    .inv_en(inv_pulse), .inv_val(inv_val), .flush(flush)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      acc_addr_q  <= '0;
      stale_q     <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_paddr   <= '0;
      rsp_cached  <= 1'b0;
      rsp_prio    <= 1'b0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      mem_rd_req <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (req_fire) begin
          acc_addr_q <= req_addr;
          rsp_fault  <= 1'b0;
          rsp_paddr  <= '0;
          rsp_cached <= 1'b0;
          rsp_prio   <= 1'b0;
          if (!xl_en) begin
            rsp_valid <= 1'b1;
            rsp_paddr <= PA_W'(req_addr);
          end else if (!in_win) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
          end else if (tlb_hit) begin
            rsp_valid  <= 1'b1;
            rsp_paddr  <= {hit_res.ppn, req_addr[PG_SH-1:0]};
            rsp_cached <= hit_res.cached;
            rsp_prio   <= hit_res.prio;
          end else if (l1_big) begin
            rsp_valid  <= 1'b1;
            rsp_paddr  <= {big_ppn(l1e[PPN_W-1:0], pg), req_addr[PG_SH-1:0]};
            rsp_cached <= l1e[1];
            rsp_prio   <= l1e[0];
          end else if (l1_ptr) begin
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= l2_addr(l1e[PPN_W-1:0], pg);
            stale_q     <= 1'b0;
            st_q        <= ST_WALK;
          end else begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
          end
        end
      end else begin
        if (cfg_evt) stale_q <= 1'b1;
        if (mem_rsp_valid) begin
          st_q      <= ST_IDLE;
          rsp_valid <= 1'b1;
          if (mem_rsp_data[31]) begin
            rsp_paddr  <= {mem_rsp_data[PPN_W-1:0], acc_addr_q[PG_SH-1:0]};
            rsp_cached <= mem_rsp_data[30];
          end else begin
            rsp_fault <= 1'b1;
          end
        end
      end
    end
  end

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0 && !rsp_cached && !rsp_prio); // R12
  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[PG_SH-1:0] == acc_addr_q[PG_SH-1:0]); // R6
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req); // R4
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !req_ready); // R11
  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && xl_en && in_win && tlb_hit |=> rsp_valid && !mem_rd_req); // R7
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !xl_en |=> rsp_valid && !rsp_fault && rsp_paddr == PA_W'($past(req_addr))); // R2
endmodule

// File: tb/sim_iomap_xlate.sv
`timescale 1ns/1ps
module sim_iomap_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [8:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_addr = '0;
  logic        rsp_valid, rsp_fault, rsp_cached, rsp_prio;
  logic [41:0] rsp_paddr;
  logic        mem_rd_req;
  logic [41:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int fails = 0;
  int rd_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  iomap_xlate u0 (.*);

  function automatic logic [31:0] l1val(input int i);
    case (i % 4)
      3: return 32'h0;
      2: return 32'h8000_0000 | 32'(i << 14) | 32'(((i >> 2) & 1) << 1) | 32'((i >> 3) & 1);
      default: return 32'h4000_0000 | 32'(32'h8000 + i * 8);
    endcase
  endfunction

  function automatic logic [31:0] memword(input longint unsigned la);
    longint unsigned w;
    w = la >> 2;
    return {((w & 7) != 7), w[3], 30'((w ^ 64'h155) & 64'h3FFF_FFFF)};
  endfunction

  // bench model of one translation with translation enabled
  function automatic void model(input longint unsigned a, input int code, output bit flt,
                                output longint unsigned pa, output bit c, output bit p, output bit walk);
    int hi, lo;
    longint unsigned l1, off, la;
    logic [31:0] w;
    flt = 0; pa = 0; c = 0; p = 0; walk = 0;
    case (code)
      0: begin hi = 28; lo = 22; end
      1: begin hi = 31; lo = 25; end
      3: begin hi = 37; lo = 31; end
      default: begin flt = 1; return; end
    endcase
    if ((a >> hi) != 0) begin flt = 1; return; end
    l1  = 64'(l1val(int'((a >> lo) & 63)));
    off = (a & ((64'd1 << lo) - 1)) >> 12;
    if (l1[31]) begin
      pa = (((l1 & 64'h3FFF_FFFC) + off) << 12) | (a & 64'hFFF);
      c = l1[1]; p = l1[0];
    end else if (l1[30]) begin
      walk = 1;
      la = ((l1 & 64'h3FFF_FFFF) << 12) + off * 4;
      w = memword(la);
      if (!w[31]) flt = 1;
      else begin
        pa = (64'(w & 32'h3FFF_FFFF) << 12) | (a & 64'hFFF);
        c = w[30];
      end
    end else flt = 1;
  endfunction

  // memory model: answers a read two cycles after seeing it
  bit pend = 0;
  int cd = 0;
  logic [41:0] lat_addr;
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (cd == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = memword(64'(lat_addr));
        pend = 0;
      end else cd--;
    end
    if (mem_rd_req) begin
      pend = 1; cd = 1; lat_addr = mem_rd_addr; rd_cnt++;
    end
  end

  task automatic chk(input bit ok, input string rq, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [8:0] a, input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic xlate(input logic [39:0] a, output bit flt, output longint unsigned pa, output bit c,
                       output bit p, output int lat, output int nrd, output bit rdy_after);
    int r0;
    r0 = rd_cnt;
    req_addr = a; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rdy_after = req_ready;
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    flt = rsp_fault; pa = 64'(rsp_paddr); c = rsp_cached; p = rsp_prio;
    nrd = rd_cnt - r0;
  endtask

  // translate and compare against the model; returns fault/walk of the model
  task automatic run_cmp(input longint unsigned a, input int code, output bit eflt, output bit ewalk);
    bit flt, c, p, ec, ep, rdy;
    longint unsigned pa, epa;
    int lat, nrd;
    model(a, code, eflt, epa, ec, ep, ewalk);
    xlate(40'(a), flt, pa, c, p, lat, nrd, rdy);
    chk(flt == eflt, ewalk ? "R6" : "R5", 64'(flt), 64'(eflt));
    chk(pa == epa, "R4", pa, epa);
    chk(c == ec && p == ep, "R5", {c, p}, {ec, ep});
    chk(nrd == (ewalk ? 1 : 0), "R4", 64'(nrd), 64'(ewalk));
    if (ewalk) begin
      chk(lat > 1, "R11", 64'(lat), 2);
      chk(rdy == 1'b0, "R11", 64'(rdy), 0);
    end else chk(lat == 1, "R3", 64'(lat), 1);
  endtask

  task automatic expect_reads(input longint unsigned a, input int n, input string rq);
    bit flt, c, p, rdy;
    longint unsigned pa;
    int lat, nrd;
    xlate(40'(a), flt, pa, c, p, lat, nrd, rdy);
    chk(nrd == n, rq, 64'(nrd), 64'(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit flt, c, p, rdy, ef, ew;
    longint unsigned pa, a;
    int lat, nrd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cfg_addr = 9'h100; #1;
    chk(req_ready == 1'b1, "R1", 64'(req_ready), 1);
    chk(rsp_valid == 1'b0 && mem_rd_req == 1'b0, "R1", {rsp_valid, mem_rd_req}, 0);
    chk(cfg_rdata == 32'h0, "R1", 64'(cfg_rdata), 0);
    @(negedge clk);

    // R2 bypass while disabled
    foreach (pa_list[k]) begin
      xlate(pa_list[k], flt, pa, c, p, lat, nrd, rdy);
      chk(!flt && pa == 64'(pa_list[k]), "R2", pa, 64'(pa_list[k]));
      chk(lat == 1 && nrd == 0, "R2", 64'(lat), 1);
    end

    // program first-level entries and enable with the 2 GiB window
    for (int i = 0; i < 64; i++) cfg_write(9'(i * 4), l1val(i));
    cfg_addr = 9'h2C; #1;
    chk(cfg_rdata == l1val(11), "R4", 64'(cfg_rdata), 64'(l1val(11)));
    cfg_write(9'h100, 32'h101);
    cfg_addr = 9'h100; #1;
    chk(cfg_rdata == 32'h101, "R3", 64'(cfg_rdata), 64'h101);
    @(negedge clk);

    // sweep of all first-level entries, two pages each, repeated for hits
    for (int i = 0; i < 64; i++) begin
      for (int k = 0; k < 2; k++) begin
        longint unsigned idx, epa;
        bit ec, ep;
        idx = (k == 1) ? 64'h0AB7 : 64'((i * 3) & 16'h1FFF);
        a = (64'(i) << 25) | (idx << 12) | 64'((i * 37) & 12'hFFF);
        run_cmp(a, 1, ef, ew);
        model(a, 1, ef, epa, ec, ep, ew);
        xlate(40'(a), flt, pa, c, p, lat, nrd, rdy);
        if (!ef) begin
          chk(lat == 1 && nrd == 0, "R7", 64'(nrd), 0);
          chk(pa == epa && c == ec && p == ep, "R7", pa, epa);
        end else begin
          chk(flt && pa == 0, "R12", pa, 0);
          chk(nrd == (ew ? 1 : 0), "R12", 64'(nrd), 64'(ew));
        end
      end
    end

    // window limits
    run_cmp(64'h8000_0000, 1, ef, ew);
    chk(ef == 1'b1, "R3", 64'(ef), 1);
    cfg_write(9'h100, 32'h102);
    run_cmp(64'h0, 2, ef, ew);
    chk(flt == 1'b0 || ef == 1'b1, "R3", 64'(ef), 1);
    cfg_write(9'h100, 32'h100);
    run_cmp(64'h1000_0000, 0, ef, ew);
    for (int i = 0; i < 64; i += 5)
      run_cmp((64'(i) << 22) | (64'((i * 7) & 10'h3FF) << 12) | 64'h5A, 0, ef, ew);
    cfg_write(9'h100, 32'h103);
    run_cmp(64'h20_0000_0000, 3, ef, ew);
    run_cmp(64'h1F_FFFF_FFFF, 3, ef, ew);
    for (int i = 0; i < 64; i += 7)
      run_cmp((64'(i) << 31) | (64'((i * 11) & 20'h7FFFF) << 12) | 64'(i), 3, ef, ew);

    // R8 round-robin replacement
    cfg_write(9'h100, 32'h101);
    for (int j = 0; j < 9; j++) expect_reads(64'(j * 8) << 12, 1, "R8");
    expect_reads(64'(2 * 8) << 12, 0, "R8");
    expect_reads(64'(0) << 12, 1, "R8");
    expect_reads(64'(1 * 8) << 12, 1, "R8");

    // R9 invalidate by 16 KiB region
    cfg_write(9'h100, 32'h101);
    expect_reads((64'd1 << 25) | (64'h10 << 12), 1, "R9");
    expect_reads((64'd1 << 25) | (64'h11 << 12), 1, "R9");
    expect_reads((64'd1 << 25) | (64'h14 << 12), 1, "R9");
    cfg_write(9'h104, 32'(((64'd1 << 25) | (64'h10 << 12)) >> 14));
    expect_reads((64'd1 << 25) | (64'h14 << 12), 0, "R9");
    expect_reads((64'd1 << 25) | (64'h11 << 12), 1, "R9");
    expect_reads((64'd1 << 25) | (64'h10 << 12), 1, "R9");

    // R10 flush on configuration writes
    expect_reads((64'd1 << 25) | (64'h14 << 12), 0, "R10");
    cfg_write(9'h004, l1val(1));
    expect_reads((64'd1 << 25) | (64'h14 << 12), 1, "R10");
    cfg_write(9'h100, 32'h101);
    expect_reads((64'd1 << 25) | (64'h14 << 12), 1, "R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  logic [39:0] pa_list [3] = '{40'h0, 40'hFF_FFFF_FFFF, 40'h12_3456_789A};
endmodule